// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a synchronous DRAM from power-on to a usable state. After reset it holds the command bus quiet for a configurable stabilization interval. It then closes every bank with one precharge, issues two auto-refresh commands and writes the mode register with an operating word supplied on an input. When the last required gap has elapsed, it raises a ready flag. A single down-counter times each step, so every gap is a parameter counted in clock cycles.

The mode word is cleaned before it is written. The reserved high bits and the operating-mode field are forced to zero. A CAS-latency field that the memory does not support is replaced with a safe default of 3, and a sticky flag reports that substitution. The clock-enable pin stays high and the bank-address pins stay at zero for the whole sequence. The block does no normal accesses and no periodic refresh; once ready rises, a separate controller is expected to take over the bus.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While reset is asserted (asynchronous, active low), the command pins show command inhibit ({cs_n,ras_n,cas_n,we_n} = 4'b1111), the address and bank pins are zero, cke is 1, and init_done and cl_fixed are 0.
- R2: Counting clock edges from reset release as 1, 2, …, the command after edges 1 through WAIT_CYC-1 is NOP (4'b0111) with address zero. WAIT_CYC must be at least 2.
- R3: After edge WAIT_CYC, a single precharge-all command appears (4'b0010). The address is 13'h0400, with bit 10 set to select all banks.
- R4: The first auto refresh (4'b0001, address zero) comes TRP_CYC edges after the precharge, with only NOPs in between.
- R5: The second auto refresh comes TRFC_CYC edges after the first. The mode-register load comes TRFC_CYC edges after the second. Only NOPs appear in between.
- R6: The mode-register load is 4'b0000 and lasts one cycle. Address bits 3:0, 6:4 and 9 carry the matching bits of mode_word. Address bits 8:7 and 12:10 are zero.
- R7: If mode_word[6:4] is 3'b010 or 3'b011, that value is loaded unchanged and cl_fixed stays 0. Any other value is loaded as 3'b011, and cl_fixed rises with the load command and stays high until reset.
- R8: init_done rises TMRD_CYC+1 edges after the mode-register load and stays high. Every command from the load onward is NOP.
- R9: cke is 1 and ba is zero in every cycle.
- R10: Reset asserted at any point of the sequence returns the outputs to the R1 state at once. After release, the whole sequence restarts from the beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all outputs are registered on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; starts the sequence on release |
| mode_word | input | 12 | Requested mode-register operating word; must be stable before the load step |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 13 | Memory address bus |
| ba | output | 2 | Bank address, always zero |
| cke | output | 1 | Clock enable, always high |
| init_done | output | 1 | High once initialization is complete |
| cl_fixed | output | 1 | Sticky flag: the requested CAS latency was replaced |

## Verification
The sequence is run with mode words that differ in burst length, burst type, write-burst bit and CAS latency. Every cycle of each run is compared against a timeline computed from the parameters. Legal latencies of 2 and 3 show that a valid word passes through untouched. Latencies of 0, 5 and 7 show that the latency is replaced and flagged. An all-ones word and a word with the operating-mode bits set show that the reserved fields and operating-mode bits are cleared while the neighbouring fields survive. A reset in the middle of the refresh phase, and a reset after a flagged run, confirm that the sequence and the sticky flag both restart.

// File: rtl/sdi_pkg.sv
package sdi_pkg;

  localparam int unsigned ADDR_W      = 13;
  localparam int unsigned OP_W        = 12;
  localparam int unsigned ALLBANK_BIT = 10;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_INHIBIT = 4'b1111,
    CMD_NOP     = 4'b0111,
    CMD_PRE     = 4'b0010,
    CMD_REF     = 4'b0001,
    CMD_MRS     = 4'b0000
  } sdi_cmd_e;

  typedef enum logic [2:0] {
    ST_STAB,
    ST_PRE,
    ST_REF1,
    ST_REF2,
    ST_MRS,
    ST_DONE
  } sdi_step_e;

endpackage

// File: rtl/sdi_gap_timer.sv
module sdi_gap_timer #(
  parameter int unsigned           CNT_W   = 16,
  parameter logic [CNT_W-1:0]      RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= RST_VAL;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
  end

  assign zero = (cnt == '0);

  // R2: an idle timer walks down one step per edge
  a_r2_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R5: a new gap starts from the loaded value
  a_r5_timer_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/sdi_mode_fix.sv
module sdi_mode_fix
  import sdi_pkg::*;
#(
  parameter int unsigned CL_DEFAULT = 3
) (
  input  logic [OP_W-1:0]   mode_in,
  output logic [ADDR_W-1:0] op_out,
  output logic              cl_bad
);

  localparam int unsigned BL_LO = 0, BL_HI = 2;
  localparam int unsigned BT_BIT = 3;
  localparam int unsigned CL_LO = 4, CL_HI = 6;
  localparam int unsigned WB_BIT = 9;

  logic [CL_HI-CL_LO:0] cl_req;

  assign cl_req = mode_in[CL_HI:CL_LO];
  assign cl_bad = !((cl_req == 3'd2) || (cl_req == 3'd3));

  always_comb begin
    op_out               = '0;
    op_out[BL_HI:BL_LO]  = mode_in[BL_HI:BL_LO];
    op_out[BT_BIT]       = mode_in[BT_BIT];
    op_out[CL_HI:CL_LO]  = cl_bad ? 3'(CL_DEFAULT) : cl_req;
    op_out[WB_BIT]       = mode_in[WB_BIT];
  end

endmodule

// File: rtl/sdi_step_ctrl.sv
module sdi_step_ctrl
  import sdi_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TRP_CYC  = 4,
  parameter int unsigned TRFC_CYC = 14,
  parameter int unsigned TMRD_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              zero,
  input  logic [ADDR_W-1:0] op_word,
  input  logic              cl_bad,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output sdi_cmd_e          cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o,
  output logic              cl_flag_o
);

  sdi_step_e         step, nstep;
  sdi_cmd_e          ncmd;
  logic [ADDR_W-1:0] naddr;

  always_comb begin
    case (step)
      ST_STAB: nstep = ST_PRE;
      ST_PRE:  nstep = ST_REF1;
      ST_REF1: nstep = ST_REF2;
      ST_REF2: nstep = ST_MRS;
      default: nstep = ST_DONE;
    endcase
  end

  always_comb begin
    ncmd     = CMD_NOP;
    naddr    = '0;
    load_val = '0;
    case (nstep)
      ST_PRE: begin
        ncmd               = CMD_PRE;
        naddr[ALLBANK_BIT] = 1'b1;
        load_val           = CNT_W'(TRP_CYC - 1);
      end
      ST_REF1, ST_REF2: begin
        ncmd     = CMD_REF;
        load_val = CNT_W'(TRFC_CYC - 1);
      end
      ST_MRS: begin
        ncmd     = CMD_MRS;
        naddr    = op_word;
        load_val = CNT_W'(TMRD_CYC - 1);
      end
      default: ;
    endcase
  end

  assign load = zero && (step != ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step      <= ST_STAB;
      cmd_o     <= CMD_INHIBIT;
      addr_o    <= '0;
      done_o    <= 1'b0;
      cl_flag_o <= 1'b0;
    end else begin
      done_o <= (step == ST_DONE);
      if (load) begin
        step   <= nstep;
        cmd_o  <= ncmd;
        addr_o <= naddr;
        if (nstep == ST_MRS) cl_flag_o <= cl_bad;
      end else begin
        cmd_o  <= CMD_NOP;
        addr_o <= '0;
      end
    end
  end

  // R3: a precharge always targets all banks
  a_r3_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_PRE) |-> addr_o[ALLBANK_BIT]);

  // R6: reserved and operating-mode bits are clear in the loaded word
  a_r6_mrs_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (addr_o[12:10] == 3'b000 && addr_o[8:7] == 2'b00));

  // R7: only supported latencies reach the mode register
  a_r7_cl_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_MRS) |-> (addr_o[6:4] == 3'd2 || addr_o[6:4] == 3'd3));

  // R7: the substitution flag is sticky
  a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cl_flag_o |=> cl_flag_o);

  // R8: ready never drops and the bus stays idle behind it
  a_r8_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd_o == CMD_NOP));

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdi_pkg::*;
#(
  parameter int unsigned WAIT_CYC   = 20000,
  parameter int unsigned TRP_CYC    = 4,
  parameter int unsigned TRFC_CYC   = 14,
  parameter int unsigned TMRD_CYC   = 2,
  parameter int unsigned CL_DEFAULT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] mode_word,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic [12:0] addr,
  output logic [1:0]  ba,
  output logic        cke,
  output logic        init_done,
  output logic        cl_fixed
);

  localparam int unsigned CNT_W = $clog2(WAIT_CYC + TRP_CYC + TRFC_CYC + TMRD_CYC + 1);
  localparam logic [CNT_W-1:0] WAIT_LOAD = CNT_W'(WAIT_CYC - 1);

  logic              t_load, t_zero, cl_bad;
  logic [CNT_W-1:0]  t_val;
  logic [ADDR_W-1:0] op_word;
  sdi_cmd_e          cmd;

  sdi_gap_timer #(.CNT_W(CNT_W), .RST_VAL(WAIT_LOAD)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .zero(t_zero)
  );

  sdi_mode_fix #(.CL_DEFAULT(CL_DEFAULT)) u_fix (
    .mode_in(mode_word), .op_out(op_word), .cl_bad(cl_bad)
  );

  sdi_step_ctrl #(
    .CNT_W(CNT_W), .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC), .TMRD_CYC(TMRD_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .zero(t_zero), .op_word(op_word), .cl_bad(cl_bad),
    .load(t_load), .load_val(t_val), .cmd_o(cmd), .addr_o(addr),
    .done_o(init_done), .cl_flag_o(cl_fixed)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign ba  = '0;
  assign cke = 1'b1;

endmodule

// File: tb/sdram_powerup_seq_test.sv
`timescale 1ns/1ps
module sdram_powerup_seq_test;

  localparam int W = 40, P = 3, F = 7, M = 2;
  localparam int EP = W, ER1 = W + P, ER2 = W + P + F, EM = W + P + 2*F, ED = EM + M + 1;
  localparam int NV = 8;
  // {mode_word, expected address at load, expected flag}
  localparam logic [25:0] VECS [NV] = '{
    {12'h023, 13'h0023, 1'b0},
    {12'h032, 13'h0032, 1'b0},
    {12'h03B, 13'h003B, 1'b0},
    {12'h227, 13'h0227, 1'b0},
    {12'h050, 13'h0030, 1'b1},
    {12'hFFF, 13'h023F, 1'b1},
    {12'h000, 13'h0030, 1'b1},
    {12'h1A2, 13'h0022, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic [11:0] mode_word = '0;
  logic cs_n, ras_n, cas_n, we_n, cke, init_done, cl_fixed;
  logic [12:0] addr;
  logic [1:0] ba;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdram_powerup_seq #(.WAIT_CYC(W), .TRP_CYC(P), .TRFC_CYC(F), .TMRD_CYC(M)) uut (
    .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .cke(cke),
    .init_done(init_done), .cl_fixed(cl_fixed)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] exp_cmd(int k);
    if (k == EP) return 4'b0010;
    if (k == ER1 || k == ER2) return 4'b0001;
    if (k == EM) return 4'b0000;
    return 4'b0111;
  endfunction

  function automatic string tag_of(int k);
    if (k < EP) return "R2";
    if (k == EP) return "R3";
    if (k <= ER1) return "R4";
    if (k < EM) return "R5";
    if (k == EM) return "R6";
    return "R8";
  endfunction

  task automatic check_reset_state(input string req);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, req, {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk(addr == 13'h0 && ba == 2'b0 && cke == 1'b1, req, {addr, ba, cke}, 32'h1);
    chk(!init_done && !cl_fixed, req, {init_done, cl_fixed}, 0);
  endtask

  task automatic run_one(input logic [25:0] v);
    logic [12:0] xa;
    logic        xf;
    mode_word = v[25:14];
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    check_reset_state("R1");
    rst_n = 1;
    for (int k = 1; k <= ED + 4; k++) begin
      @(negedge clk);
      xa = (k == EP) ? 13'h0400 : (k == EM) ? v[13:1] : 13'h0;
      xf = (k >= EM) ? v[0] : 1'b0;
      chk({cs_n, ras_n, cas_n, we_n} == exp_cmd(k), tag_of(k), {cs_n, ras_n, cas_n, we_n}, exp_cmd(k));
      chk(addr == xa, (k == EM) ? "R6" : tag_of(k), addr, xa);
      chk(cl_fixed == xf, "R7", cl_fixed, xf);
      chk(init_done == (k >= ED), "R8", init_done, (k >= ED));
      chk(cke == 1'b1 && ba == 2'b0, "R9", {cke, ba}, 3'b100);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // table walk: R2..R9 on every cycle, R1 before each run
    for (int i = 0; i < NV; i++) run_one(VECS[i]);

    // R1: reset clears the sticky flag left by a flagged run
    run_one(VECS[4]);
    @(negedge clk);
    rst_n = 0;
    #1;
    chk(!cl_fixed && !init_done, "R1", {cl_fixed, init_done}, 0);

    // R10: reset during the refresh phase, then a full restart
    mode_word = VECS[0][25:14];
    @(negedge clk);
    rst_n = 1;
    for (int k = 1; k <= ER1 + 2; k++) @(negedge clk);
    rst_n = 0;
    #1;
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R10", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk(addr == 13'h0 && !init_done, "R10", {addr, init_done}, 0);
    run_one(VECS[1]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule